// File: doc/BRIEF.md
# Flow-Through Burst SRAM Control Model

This block is a clocked, synthesizable model of a flow-through synchronous burst SRAM with a small internal array. Every clock edge it decodes three chip selects, two address strobes, a burst-advance input and the write enables into one access. It then either loads the external address, steps or holds a two-bit burst counter, writes byte lanes, or deselects. Read data leaves the array straight from the registered burst address, with no output register. The data bus is given as a data-out vector with a separate drive enable, and a separate data-in vector.

Two strobes start bursts. The processor strobe always starts a read and is ignored while the first select is high. The controller strobe starts a read or a write depending on the write enables. When neither strobe starts a cycle, the advance input steps the burst or holds it. A sleep request overrides all of this. It removes the bus drive at once, reports full sleep after a fixed number of edges, and keeps the strobes blocked until a recovery count has passed.

Top module: `sbsram_model`

## Requirements
- R1: A burst loads `addr_in` only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at the edge, and either strobe is low.
- R2: A selected edge with `proc_strobe_n`=0 is always a read, whatever `all_wr_n`, `lane_wr_n` and `lane_sel_n` are.
- R3: `proc_strobe_n` is ignored while `sel_a_n`=1. `ctrl_strobe_n`=0 with `sel_a_n`=1 deselects. Either strobe low with `sel_b`=0 or `sel_c_n`=1 deselects. A deselected period has `dq_oe`=0.
- R4: A selected edge with `ctrl_strobe_n`=0 and `proc_strobe_n`=1 is a write when the write term is active, and a read otherwise.
- R5: The write term is active when `all_wr_n`=0, or when `lane_wr_n`=0 and any bit of `lane_sel_n` is 0. `all_wr_n`=0 writes all four 8-bit lanes. Otherwise only lane i (bits 8i+7..8i) is written for each `lane_sel_n`[i]=0.
- R6: With no strobe starting a cycle and a burst active, `burst_adv_n`=0 steps the two low address bits linearly with wrap (3 to 0) and keeps the upper bits. `burst_adv_n`=1 holds the address. The access is a read or a write per R5. After a deselect no continuation accesses.
- R7: Read data for the address of a read edge appears on `dq_out` within the same clock period as that edge.
- R8: `dq_oe` is 1 only in a read period while `out_en_n`=0. It follows `out_en_n` without a clock and is 0 in write periods.
- R9: `sleep_req`=1 forces `dq_oe` to 0 immediately, and any edge that samples it does no access.
- R10: `asleep` rises at the second consecutive edge that samples `sleep_req`=1, and falls at the first edge that samples it 0.
- R11: After `sleep_req` falls, strobes at the first two edges are treated as deselects. The third edge accepts them.
- R12: While reset is held and after release, `dq_oe` and `asleep` are 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 4 | External address |
| sel_a_n | input | 1 | First chip select, active low, gates the processor strobe |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |
| asleep | output | 1 | Full sleep reached |

## Verification
The sharpest overlap is a read burst that is still driving the bus when the sleep request rises. The combinational removal of drive and the clocked sleep counter then act on the same period. The bench raises the request mid-period during an active read with output enable low. It expects drive to drop before the next edge and the sleep flag only at the second edge. On the way out, a controller strobe is held low across the recovery edges, and only the third edge may produce read data.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    SL_AWAKE = 2'd0,
    SL_ENTER = 2'd1,
    SL_DOWN  = 2'd2,
    SL_EXIT  = 2'd3
  } sleep_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          proc_n,
  input  logic          ctrl_n,
  input  logic          adv_n,
  input  logic          all_wr_n,
  input  logic          lane_wr_n,
  input  logic [NB-1:0] lane_sel_n,
  input  logic          blocked,
  input  logic          active,
  output logic          load,
  output logic          advance,
  output op_e           op_nxt,
  output logic [NB-1:0] lane_we
);
  logic selected;
  logic wr_term;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign wr_term  = !all_wr_n || (!lane_wr_n && (lane_sel_n != '1));

  always_comb begin
    load    = 1'b0;
    advance = 1'b0;
    op_nxt  = OP_IDLE;
    if (blocked) begin
      op_nxt = OP_IDLE;
    end else if (!sel_a_n && !proc_n) begin
      if (selected) begin
        load   = 1'b1;
        op_nxt = OP_READ;
      end
    end else if (!ctrl_n) begin
      if (selected) begin
        load   = 1'b1;
        op_nxt = wr_term ? OP_WRITE : OP_READ;
      end
    end else if (active) begin
      advance = !adv_n;
      op_nxt  = wr_term ? OP_WRITE : OP_READ;
    end
  end

  always_comb begin
    if (op_nxt != OP_WRITE) lane_we = '0;
    else if (!all_wr_n)     lane_we = '1;
    else                    lane_we = ~lane_sel_n;
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNT_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          load,
  input  logic          advance,
  input  op_e           op_nxt,
  output logic [AW-1:0] addr_nxt,
  output logic [AW-1:0] addr_q,
  output op_e           op_q,
  output logic          active
);
  logic [CNT_W-1:0] cnt_inc;
  logic             addr_en;

  assign cnt_inc = addr_q[CNT_W-1:0] + CNT_W'(1);
  assign addr_en = load || advance;

  always_comb begin
    if (load)         addr_nxt = addr_in;
    else if (advance) addr_nxt = {addr_q[AW-1:CNT_W], cnt_inc};
    else              addr_nxt = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      op_q   <= OP_IDLE;
    end else begin
      if (addr_en) addr_q <= addr_nxt;
      op_q <= op_nxt;
    end
  end

  assign active = (op_q != OP_IDLE);
endmodule

// File: rtl/sbs_sleep_ctl.sv
module sbs_sleep_ctl
  import sbs_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic awake,
  output logic asleep
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  sleep_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SL_AWAKE: if (sleep_req) begin st_d = SL_ENTER; cnt_d = CW'(1); end
      SL_ENTER: begin
        if (!sleep_req) begin
          st_d = SL_EXIT; cnt_d = CW'(1);
        end else if (cnt_q >= CW'(ENTER_CYC - 1)) begin
          st_d = SL_DOWN;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      SL_DOWN: if (!sleep_req) begin st_d = SL_EXIT; cnt_d = CW'(1); end
      SL_EXIT: begin
        if (sleep_req) begin
          st_d = SL_ENTER; cnt_d = CW'(1);
        end else if (cnt_q >= CW'(EXIT_CYC - 1)) begin
          st_d = SL_AWAKE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = SL_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SL_AWAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign awake  = (st_q == SL_AWAKE);
  assign asleep = (st_q == SL_DOWN);
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic [NB-1:0]    lane_we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*LW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[l]) bank[waddr] <= wdata[l*LW +: LW];
    end
    assign rdata[l*LW +: LW] = bank[raddr];
  end
endmodule

// File: rtl/sbsram_model.sv
module sbsram_model
  import sbs_pkg::*;
#(
  parameter int AW        = 4,
  parameter int NB        = 4,
  parameter int LW        = 8,
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_in,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             burst_adv_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [NB-1:0]    lane_sel_n,
  input  logic             out_en_n,
  input  logic             sleep_req,
  input  logic [NB*LW-1:0] dq_in,
  output logic [NB*LW-1:0] dq_out,
  output logic             dq_oe,
  output logic             asleep
);
  localparam int CNT_W = 2;

  logic          rst_meta_n, rst_int_n;
  logic          sleep_awake, blocked;
  logic          dec_load, dec_adv, burst_active;
  op_e           op_nxt, op_q;
  logic [NB-1:0] lane_we;
  logic [AW-1:0] addr_nxt, cur_addr_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  sbs_sleep_ctl #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sleep_req (sleep_req),
    .awake     (sleep_awake),
    .asleep    (asleep)
  );

  assign blocked = sleep_req || !sleep_awake;

  sbs_cmd_decode #(.NB(NB)) u_dec (
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .proc_n     (proc_strobe_n),
    .ctrl_n     (ctrl_strobe_n),
    .adv_n      (burst_adv_n),
    .all_wr_n   (all_wr_n),
    .lane_wr_n  (lane_wr_n),
    .lane_sel_n (lane_sel_n),
    .blocked    (blocked),
    .active     (burst_active),
    .load       (dec_load),
    .advance    (dec_adv),
    .op_nxt     (op_nxt),
    .lane_we    (lane_we)
  );

  sbs_burst_addr #(.AW(AW), .CNT_W(CNT_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr_in  (addr_in),
    .load     (dec_load),
    .advance  (dec_adv),
    .op_nxt   (op_nxt),
    .addr_nxt (addr_nxt),
    .addr_q   (cur_addr_q),
    .op_q     (op_q),
    .active   (burst_active)
  );

  sbs_lane_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (addr_nxt),
    .wdata   (dq_in),
    .raddr   (cur_addr_q),
    .rdata   (dq_out)
  );

  // output drive: read period, asynchronous enable, sleep request masks at once
  assign dq_oe = (op_q == OP_READ) && !out_en_n && !sleep_req;
endmodule

// File: rtl/sbsram_model_chk.sv
module sbsram_model_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          proc_n,
  input logic          ctrl_n,
  input logic          adv_n,
  input logic          out_en_n,
  input logic          sleep_req,
  input logic          dq_oe,
  input logic          asleep,
  input logic          awake,
  input logic          active,
  input logic [AW-1:0] cur_addr
);
  p_sleep_tristate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !dq_oe);

  p_asleep_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(sleep_req) && $past(sleep_req, 2)));

  p_asleep_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !sleep_req) |=> !asleep);

  p_proc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !sleep_req && !sel_a_n && sel_b && !sel_c_n && !proc_n)
      |=> (dq_oe == (!out_en_n && !sleep_req)));

  p_bad_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n && !proc_n && (!sel_b || sel_c_n)) |=> !dq_oe);

  p_ctrl_unselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n && !ctrl_n) |=> !dq_oe);

  p_burst_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !sleep_req && active && (proc_n || sel_a_n) && ctrl_n && !adv_n)
      |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  p_recovery_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> !dq_oe);
endmodule

bind sbsram_model sbsram_model_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .sel_a_n   (sel_a_n),
  .sel_b     (sel_b),
  .sel_c_n   (sel_c_n),
  .proc_n    (proc_strobe_n),
  .ctrl_n    (ctrl_strobe_n),
  .adv_n     (burst_adv_n),
  .out_en_n  (out_en_n),
  .sleep_req (sleep_req),
  .dq_oe     (dq_oe),
  .asleep    (asleep),
  .awake     (sleep_awake),
  .active    (burst_active),
  .cur_addr  (cur_addr_q)
);

// File: tb/sbsram_model_tb.sv
module sbsram_model_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr_in;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        proc_strobe_n, ctrl_strobe_n, burst_adv_n;
  logic        all_wr_n, lane_wr_n;
  logic [3:0]  lane_sel_n;
  logic        out_en_n, sleep_req;
  logic [31:0] dq_in, dq_out;
  logic        dq_oe, asleep;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sbsram_model u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .burst_adv_n(burst_adv_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep_req(sleep_req),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .asleep(asleep)
  );

  typedef struct packed {
    logic        p_n;
    logic        c_n;
    logic        adv_n;
    logic        gw_n;
    logic        bwe_n;
    logic [3:0]  bw;
    logic [3:0]  addr;
    logic [31:0] din;
    logic        exp_oe;
    logic [31:0] exp;
  } vec_t;

  // chip selected and out_en_n low throughout the table
  localparam vec_t VECS [13] = '{
    '{1, 0, 1, 0, 1, 4'hF, 4'h4, 32'h11111111, 0, 32'h0},        // R4 write start
    '{1, 1, 0, 0, 1, 4'hF, 4'h0, 32'h22222222, 0, 32'h0},        // R6 write addr5
    '{1, 1, 0, 0, 1, 4'hF, 4'h0, 32'h33333333, 0, 32'h0},        // addr6
    '{1, 1, 0, 0, 1, 4'hF, 4'h0, 32'h44444444, 0, 32'h0},        // addr7
    '{1, 1, 0, 0, 1, 4'hF, 4'h0, 32'h55555555, 0, 32'h0},        // wrap to addr4
    '{0, 1, 1, 0, 0, 4'h0, 4'h5, 32'hDEADBEEF, 1, 32'h22222222}, // R2 forced read
    '{1, 1, 0, 1, 1, 4'hF, 4'h0, 32'h0,        1, 32'h33333333}, // R6 step
    '{1, 1, 1, 1, 1, 4'hF, 4'h0, 32'h0,        1, 32'h33333333}, // R6 hold
    '{1, 1, 0, 1, 1, 4'hF, 4'h0, 32'h0,        1, 32'h44444444}, // addr7
    '{1, 1, 0, 1, 1, 4'hF, 4'h0, 32'h0,        1, 32'h55555555}, // R6 wrap read
    '{1, 0, 1, 1, 0, 4'hA, 4'h5, 32'hAABBCCDD, 0, 32'h0},        // R5 lanes 0,2
    '{1, 0, 1, 1, 0, 4'hF, 4'h5, 32'h0,        1, 32'h22BB22DD}, // R5 no lane -> read
    '{1, 0, 1, 1, 1, 4'hF, 4'h4, 32'h0,        1, 32'h55555555}  // R4 read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    proc_strobe_n = 1; ctrl_strobe_n = 1; burst_adv_n = 1;
    all_wr_n = 1; lane_wr_n = 1; lane_sel_n = 4'hF;
  endtask

  task automatic edge_wait();
    @(posedge clk); #1;
  endtask

  task automatic start_read(input logic use_proc, input logic [3:0] a);
    @(negedge clk);
    idle_in();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    addr_in = a;
    if (use_proc) proc_strobe_n = 0; else ctrl_strobe_n = 0;
    edge_wait();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; addr_in = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    out_en_n = 0; sleep_req = 0; dq_in = 0;
    idle_in();
    repeat (3) @(posedge clk);
    #1;
    chk("R12 oe in reset", {31'b0, dq_oe}, 32'd0);
    chk("R12 asleep in reset", {31'b0, asleep}, 32'd0);
    @(negedge clk); rst_n = 1;
    repeat (3) edge_wait();
    @(negedge clk); burst_adv_n = 0;
    edge_wait();
    chk("R12 no burst after reset", {31'b0, dq_oe}, 32'd0);

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      proc_strobe_n = VECS[i].p_n; ctrl_strobe_n = VECS[i].c_n;
      burst_adv_n = VECS[i].adv_n; all_wr_n = VECS[i].gw_n;
      lane_wr_n = VECS[i].bwe_n; lane_sel_n = VECS[i].bw;
      addr_in = VECS[i].addr; dq_in = VECS[i].din;
      edge_wait();
      chk($sformatf("R8 vec%0d oe", i), {31'b0, dq_oe}, {31'b0, VECS[i].exp_oe});
      if (VECS[i].exp_oe)
        chk($sformatf("R7 vec%0d data", i), dq_out, VECS[i].exp);
    end

    // R3: processor strobe ignored with sel_a_n high -> burst holds addr4
    @(negedge clk); idle_in(); sel_a_n = 1; proc_strobe_n = 0; addr_in = 4'h5;
    edge_wait();
    chk("R3 proc ignored oe", {31'b0, dq_oe}, 32'd1);
    chk("R3 proc ignored data", dq_out, 32'h55555555);
    @(negedge clk); idle_in(); sel_a_n = 1; ctrl_strobe_n = 0;
    edge_wait();
    chk("R3 ctrl with sel_a_n high", {31'b0, dq_oe}, 32'd0);
    @(negedge clk); idle_in(); sel_a_n = 0; burst_adv_n = 0;
    edge_wait();
    chk("R6 no continue after deselect", {31'b0, dq_oe}, 32'd0);

    start_read(1'b0, 4'h5);
    chk("R1 ctrl start data", dq_out, 32'h22BB22DD);
    @(negedge clk); idle_in(); sel_b = 0; proc_strobe_n = 0;
    edge_wait();
    chk("R3 sel_b low", {31'b0, dq_oe}, 32'd0);
    start_read(1'b1, 4'h5);
    chk("R1 proc start oe", {31'b0, dq_oe}, 32'd1);
    @(negedge clk); idle_in(); sel_c_n = 1; ctrl_strobe_n = 0;
    edge_wait();
    chk("R3 sel_c_n high", {31'b0, dq_oe}, 32'd0);

    // R8: asynchronous output enable within one period
    start_read(1'b1, 4'h6);
    chk("R8 read oe", {31'b0, dq_oe}, 32'd1);
    out_en_n = 1; #1;
    chk("R8 async off", {31'b0, dq_oe}, 32'd0);
    out_en_n = 0; #1;
    chk("R8 async on", {31'b0, dq_oe}, 32'd1);
    chk("R7 read addr6", dq_out, 32'h33333333);

    // R9 / R10 / R11: sleep during an active read
    @(negedge clk); idle_in(); sleep_req = 1; #1;
    chk("R9 immediate tristate", {31'b0, dq_oe}, 32'd0);
    edge_wait();
    chk("R10 not asleep after 1 edge", {31'b0, asleep}, 32'd0);
    edge_wait();
    chk("R10 asleep after 2 edges", {31'b0, asleep}, 32'd1);
    edge_wait();
    @(negedge clk); sleep_req = 0; ctrl_strobe_n = 0; addr_in = 4'h6;
    edge_wait();
    chk("R10 wake flag", {31'b0, asleep}, 32'd0);
    chk("R11 blocked edge 1", {31'b0, dq_oe}, 32'd0);
    edge_wait();
    chk("R11 blocked edge 2", {31'b0, dq_oe}, 32'd0);
    edge_wait();
    chk("R11 accepted edge 3", {31'b0, dq_oe}, 32'd1);
    chk("R11 data edge 3", dq_out, 32'h33333333);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule